// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block sends bytes over a two-wire synchronous link made of a serial clock and a data line. A host writes a byte into a holding register. When the block is idle and no receive error is pending, it moves that byte into a shift register and sends it least significant bit first, one bit per serial clock period. Each data bit changes on a falling clock edge, so a receiver can sample it on the rising edge. The clock line stays high between frames.

The serial clock comes from one of two sources, chosen by a mode input. The block can make the clock itself by dividing the system clock by an even ratio. It can also follow an external clock that is brought into the system clock domain through a synchronizer.

Two flags report progress. The holding-empty flag shows that the holding register can take a new byte. The done flag shows that the line has gone idle. The holding register is checked once more as the last bit of each frame goes out. If a new byte is waiting at that moment, its frame follows with no gap. Each flag drives an interrupt request output, gated by its own enable.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset, `hold_empty` and `tx_done` are 1, and `sclk_out` and `sdata_out` are both 1.
- R2: A cycle with `wr_en` high stores `wr_data` and clears both `hold_empty` and `tx_done` from the next cycle.
- R3: When idle, with `hold_empty` at 0, `rx_err` all zero and no write in that cycle, the byte is moved into the shift register and `hold_empty` returns to 1. `irq_empty` equals `hold_empty` AND `irq_empty_en`, delayed by one cycle.
- R4: A frame is 8 bits, bit 0 first. `sdata_out` changes only on a falling serial clock edge, so each bit is stable at the following rising edge.
- R5: With `ext_clk_mode`=0, `sclk_out` has a period of 2*max(`half_div`,1) system cycles during a frame, and it is 1 whenever the block is idle.
- R6: With `ext_clk_mode`=1, bits advance on the falling edges of `ext_sclk`, after synchronization, and `sclk_out` stays 1.
- R7: A byte written before the falling edge that sends bit 7 of the current frame is loaded at that edge. Its first rising clock edge then comes one full clock period after the last rising edge of the previous frame.
- R8: If `hold_empty` is 1 when bit 7 is sent, `tx_done` becomes 1. `irq_done` equals `tx_done` AND `irq_done_en`, delayed by one cycle.
- R9: After the last frame, `sdata_out` holds the value of bit 7 of that frame and `sclk_out` stays 1.
- R10: While any bit of `rx_err` (overrun, framing or parity error) is 1, no frame starts, even when `hold_empty` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| ext_clk_mode | input | 1 | 0: internal divided clock; 1: follow `ext_sclk` |
| half_div | input | 8 | Half serial period in system cycles (0 is treated as 1) |
| ext_sclk | input | 1 | External serial clock |
| rx_err | input | 3 | Pending receive errors {overrun, framing, parity} |
| irq_empty_en | input | 1 | Enable for the holding-empty interrupt |
| irq_done_en | input | 1 | Enable for the done interrupt |
| sclk_out | output | 1 | Serial clock output (internal mode) |
| sdata_out | output | 1 | Serial data output |
| hold_empty | output | 1 | Holding register can take a byte |
| tx_done | output | 1 | Transmission finished, line idle |
| irq_empty | output | 1 | Holding-empty interrupt request |
| irq_done | output | 1 | Done interrupt request |

## Verification
The hardest case to reach is chaining frames without a gap. The second byte must arrive after the first has been moved into the shift register but before bit 7 goes out. The bench polls `hold_empty` and writes the second byte as soon as that flag rises. It then timestamps every rising serial clock edge and checks that all gaps across the frame boundary are the same. The external clock case is reached by having the bench drive `ext_sclk` itself, a fixed number of periods, once a frame has started.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } ssx_state_t;
endpackage

// File: rtl/ssx_sclk_gen.sv
module ssx_sclk_gen #(
  parameter int DIVW        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            ext_mode,
  input  logic [DIVW-1:0] half,
  input  logic            ext_sclk,
  output logic            fall_tick,
  output logic            rise_tick,
  output logic            sclk_q
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [DIVW-1:0]        cnt;
  logic [DIVW-1:0]        lim;
  logic                   int_tick;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev;
  logic                   ext_fall;
  logic                   ext_rise;

  assign lim      = (half == '0) ? DIVW'(1) : half;
  assign int_tick = en && !ext_mode && (cnt == lim - DIVW'(1));

  // external clock synchronizer chain
  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b1;
    else     sync_q[0] <= ext_sclk;
  end

  genvar gi;
  generate
    for (gi = 1; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[gi] <= 1'b1;
        else     sync_q[gi] <= sync_q[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ext_prev <= 1'b1;
    else     ext_prev <= sync_q[LAST];
  end

  assign ext_fall  = en && ext_mode && ext_prev && !sync_q[LAST];
  assign ext_rise  = en && ext_mode && !ext_prev && sync_q[LAST];
  assign fall_tick = (int_tick && sclk_q) || ext_fall;
  assign rise_tick = (int_tick && !sclk_q) || ext_rise;

  // internal divider; clock parks high when disabled or external
  always_ff @(posedge clk) begin
    if (rst || !en || ext_mode) begin
      cnt    <= '0;
      sclk_q <= 1'b1;
    end else if (int_tick) begin
      cnt    <= '0;
      sclk_q <= !sclk_q;
    end else begin
      cnt    <= cnt + DIVW'(1);
    end
  end

  assert_fall_drops_clk_R5: assert property (@(posedge clk) disable iff (rst)
    (fall_tick && !ext_mode) |=> !sclk_q);

  assert_ext_clk_parked_R6: assert property (@(posedge clk) disable iff (rst)
    ext_mode |=> sclk_q);
endmodule

// File: rtl/ssx_shreg.sv
module ssx_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         shift,
  output logic         dout
);
  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      dout <= 1'b1;
    end else begin
      if (shift) dout <= sh[0];
      if (load)       sh <= load_data;
      else if (shift) sh <= sh >> 1;
    end
  end

  assert_dout_holds_R4: assert property (@(posedge clk) disable iff (rst)
    !shift |=> $stable(dout));
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
  import ssx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIVW        = 8,
  parameter int ERR_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_clk_mode,
  input  logic [DIVW-1:0]   half_div,
  input  logic              ext_sclk,
  input  logic [ERR_W-1:0]  rx_err,
  input  logic              irq_empty_en,
  input  logic              irq_done_en,
  output logic              sclk_out,
  output logic              sdata_out,
  output logic              hold_empty,
  output logic              tx_done,
  output logic              irq_empty,
  output logic              irq_done
);
  localparam int IDXW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDXW-1:0] MSB_IDX = IDXW'(DATA_W - 1);

  ssx_state_t        state;
  logic [IDXW-1:0]   idx;
  logic [DATA_W-1:0] hold_q;
  logic              chain_q;
  logic              fall_tick;
  logic              rise_tick;
  logic              err_any;
  logic              start;
  logic              msb_fall;
  logic              chain;
  logic              load;

  assign err_any  = |rx_err;
  assign start    = (state == ST_IDLE) && !hold_empty && !err_any && !wr_en;
  assign msb_fall = (state == ST_SEND) && fall_tick && (idx == MSB_IDX);
  assign chain    = msb_fall && !hold_empty && !err_any && !wr_en;
  assign load     = start || chain;

  ssx_sclk_gen #(.DIVW(DIVW), .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk       (clk),
    .rst       (rst),
    .en        (state == ST_SEND),
    .ext_mode  (ext_clk_mode),
    .half      (half_div),
    .ext_sclk  (ext_sclk),
    .fall_tick (fall_tick),
    .rise_tick (rise_tick),
    .sclk_q    (sclk_out)
  );

  ssx_shreg #(.W(DATA_W)) u_sh (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_data (hold_q),
    .shift     (fall_tick),
    .dout      (sdata_out)
  );

  // holding register and flags
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      hold_empty <= 1'b1;
      tx_done    <= 1'b1;
    end else if (wr_en) begin
      hold_q     <= wr_data;
      hold_empty <= 1'b0;
      tx_done    <= 1'b0;
    end else begin
      if (load) hold_empty <= 1'b1;
      if (msb_fall && hold_empty) tx_done <= 1'b1;
    end
  end

  // frame sequencing: idx counts bits, advanced on rising edges
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      idx     <= '0;
      chain_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_SEND;
            idx   <= '0;
          end
        end
        ST_SEND: begin
          if (msb_fall) chain_q <= chain;
          if (rise_tick) begin
            if (idx == MSB_IDX) begin
              idx <= '0;
              if (!chain_q) state <= ST_IDLE;
            end else begin
              idx <= idx + IDXW'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_empty <= 1'b0;
      irq_done  <= 1'b0;
    end else begin
      irq_empty <= hold_empty && irq_empty_en;
      irq_done  <= tx_done && irq_done_en;
    end
  end

  assert_idle_clk_high_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> sclk_out);

  assert_load_empties_R3: assert property (@(posedge clk) disable iff (rst)
    start |=> (hold_empty && state == ST_SEND));

  assert_err_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && err_any) |=> (state == ST_IDLE));

  assert_write_clears_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (!hold_empty && !tx_done));

  assert_done_on_msb_R8: assert property (@(posedge clk) disable iff (rst)
    (msb_fall && hold_empty && !wr_en) |=> tx_done);
endmodule

// File: tb/sim_sync_ser_tx.sv
module sim_sync_ser_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       ext_clk_mode = 1'b0;
  logic [7:0] half_div = 8'd1;
  logic       ext_sclk = 1'b1;
  logic [2:0] rx_err = '0;
  logic       irq_empty_en = 1'b0;
  logic       irq_done_en = 1'b0;
  logic       sclk_out, sdata_out, hold_empty, tx_done, irq_empty, irq_done;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int ncap = 0;
  logic cap_bits [0:31];
  int   cap_ts   [0:31];
  logic mon_last = 1'b1;
  logic sclk_low_seen = 1'b0;

  always #2.5 clk = !clk;

  sync_ser_tx u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ext_clk_mode(ext_clk_mode), .half_div(half_div), .ext_sclk(ext_sclk),
    .rx_err(rx_err), .irq_empty_en(irq_empty_en), .irq_done_en(irq_done_en),
    .sclk_out(sclk_out), .sdata_out(sdata_out), .hold_empty(hold_empty),
    .tx_done(tx_done), .irq_empty(irq_empty), .irq_done(irq_done)
  );

  // capture the data line at every rising edge of the active serial clock
  always @(negedge clk) begin
    logic mclk;
    cyc++;
    mclk = ext_clk_mode ? ext_sclk : sclk_out;
    if (!sclk_out) sclk_low_seen = 1'b1;
    if (!mon_last && mclk && ncap < 32) begin
      cap_bits[ncap] = sdata_out;
      cap_ts[ncap]   = cyc;
      ncap++;
    end
    mon_last = mclk;
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done();
    while (!tx_done) @(negedge clk);
  endtask

  function automatic logic [7:0] cap_byte(input int base);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = cap_bits[base + i];
    return r;
  endfunction

  // {data[17:10], half[9:2], irq_empty_en[1], irq_done_en[0]}
  localparam logic [17:0] VEC [4] = '{
    {8'hA5, 8'd1, 1'b1, 1'b1},
    {8'h3C, 8'd2, 1'b0, 1'b1},
    {8'h81, 8'd4, 1'b1, 1'b0},
    {8'hFE, 8'd0, 1'b0, 1'b0}
  };

  initial begin
    ticks(3);
    rst = 1'b0;
    ticks(1);
    // R1 reset state
    check(hold_empty == 1'b1, "R1 hold_empty", hold_empty, 1);
    check(tx_done == 1'b1, "R1 tx_done", tx_done, 1);
    check(sclk_out == 1'b1 && sdata_out == 1'b1, "R1 lines", {sclk_out, sdata_out}, 3);

    for (int v = 0; v < 4; v++) begin
      logic [7:0] d;
      int hl;
      d = VEC[v][17:10];
      half_div = VEC[v][9:2];
      irq_empty_en = VEC[v][1];
      irq_done_en = VEC[v][0];
      hl = (VEC[v][9:2] == 0) ? 1 : int'(VEC[v][9:2]);
      ncap = 0;
      write_byte(d);
      check(!hold_empty && !tx_done, "R2 flags cleared by write", {hold_empty, tx_done}, 0);
      ticks(3);
      check(hold_empty == 1'b1, "R3 empty after load", hold_empty, 1);
      check(irq_empty == VEC[v][1], "R3 irq_empty", irq_empty, VEC[v][1]);
      wait_done();
      ticks(4 * hl + 4);
      check(ncap == 8, "R4 bit count", ncap, 8);
      check(cap_byte(0) == d, "R4 byte LSB first", cap_byte(0), d);
      check(cap_ts[1] - cap_ts[0] == 2 * hl, "R5 serial period", cap_ts[1] - cap_ts[0], 2 * hl);
      check(tx_done == 1'b1, "R8 tx_done", tx_done, 1);
      check(irq_done == VEC[v][0], "R8 irq_done", irq_done, VEC[v][0]);
      check(sdata_out == d[7], "R9 line holds bit 7", sdata_out, d[7]);
      check(sclk_out == 1'b1, "R9 clock parked high", sclk_out, 1);
    end

    // R7 back-to-back chaining
    half_div = 8'd3;
    ncap = 0;
    write_byte(8'h5A);
    while (!hold_empty) @(negedge clk);
    write_byte(8'hC3);
    check(tx_done == 1'b0, "R7 not done mid chain", tx_done, 0);
    wait_done();
    ticks(20);
    check(ncap == 16, "R7 chained bit count", ncap, 16);
    check(cap_byte(0) == 8'h5A, "R7 first byte", cap_byte(0), 8'h5A);
    check(cap_byte(8) == 8'hC3, "R7 second byte", cap_byte(8), 8'hC3);
    begin
      int bad = 0;
      for (int i = 1; i < 16; i++) if (cap_ts[i] - cap_ts[i-1] != 6) bad++;
      check(bad == 0, "R7 no gap between frames", bad, 0);
    end

    // R10 receive error blocks start
    rx_err = 3'b100;
    ncap = 0;
    write_byte(8'h99);
    ticks(60);
    check(hold_empty == 1'b0, "R10 held while error", hold_empty, 0);
    check(ncap == 0 && sclk_out == 1'b1, "R10 no clock while error", ncap, 0);
    rx_err = 3'b000;
    wait_done();
    ticks(20);
    check(ncap == 8 && cap_byte(0) == 8'h99, "R10 sends after error clears", cap_byte(0), 8'h99);

    // R6 external clock
    ext_clk_mode = 1'b1;
    ncap = 0;
    write_byte(8'h6B);
    ticks(2);
    sclk_low_seen = 1'b0;
    for (int p = 0; p < 8; p++) begin
      @(posedge clk); #1 ext_sclk = 1'b0;
      ticks(5);
      @(posedge clk); #1 ext_sclk = 1'b1;
      ticks(5);
    end
    ticks(6);
    check(ncap == 8 && cap_byte(0) == 8'h6B, "R6 external byte", cap_byte(0), 8'h6B);
    check(!sclk_low_seen, "R6 sclk_out parked", sclk_low_seen, 0);
    check(tx_done == 1'b1 && sdata_out == 1'b0, "R9 external end state", {tx_done, sdata_out}, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule